// File: doc/BRIEF.md
# Atomic Word Memory Unit

This block is a private on-chip word store that processors reach only through dedicated indivisible operations. Ordinary load and store paths, caches and address translation never see it. A caller names a word by a handle, which is a word index into the store. Each request carries an opcode, a handle and an operand. The unit performs the whole read-modify-write in one step and returns the value the word held before the operation.

Up to `N_REQ` requesters share the store. One request is granted per cycle, by round robin or by fixed priority (a parameter selects which). The result appears with a done strobe on the granted requester's response lanes one cycle after the grant.

Words are handed out and taken back by the unit itself, through a used-word bitmap. An allocate request returns the lowest free handle. When every word is in use, the allocate reports an error instead.

Operation codes on `req_op` (3 bits): 0 read, 1 write, 2 test-and-set, 3 exchange, 4 increment, 5 decrement, 6 allocate, 7 free.

A requester keeps its request stable until it sees its done strobe. While its strobe is high, the requester is not eligible for a grant. It may therefore present its next request in that same cycle, and that request is taken from the following cycle on.

Top module: `atomic_word_unit`

## Requirements
- R1: After reset no done strobe is high and every word is free, so the first allocate returns handle 0.
- R2: Read (code 0) returns the addressed word and leaves it unchanged.
- R3: Write (code 1) stores the operand and returns the previous value.
- R4: Test-and-set (code 2) returns the previous value and leaves the word equal to 1.
- R5: Exchange (code 3) stores the operand and returns the previous value.
- R6: Increment (code 4) and decrement (code 5) add or subtract one modulo 2^DATA_W and return the previous value.
- R7: A granted request raises its requester's done strobe in exactly the next cycle, with the result on that requester's data lane and the error bit beside it.
- R8: At most one request is granted per cycle. A requester whose done strobe is high is not granted. With round robin, two requesters that keep requesting are served alternately.
- R9: Allocate (code 6) returns the lowest free handle on the data lane with the error bit low, marks that handle used and clears its word to 0.
- R10: Allocate with no free word returns the error bit high and data 0, and changes no word and no handle's state.
- R11: Free (code 7) returns the word's value and releases the handle. Freeing a handle that is already free returns the error bit high and changes nothing.
- R12: Concurrent increments of one word from different requesters are all applied, and each returns a distinct previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request pending, one bit per requester |
| req_op | input | N_REQ*3 | Operation code per requester |
| req_handle | input | N_REQ*log2(DEPTH) | Word handle per requester |
| req_wdata | input | N_REQ*DATA_W | Operand per requester |
| rsp_done | output | N_REQ | One-cycle completion strobe per requester |
| rsp_data | output | N_REQ*DATA_W | Previous word value, or the allocated handle |
| rsp_err | output | N_REQ | Exhausted store on allocate, or double free |

## Verification
The assertions assume that each requester holds its opcode, handle and operand steady from the cycle it raises valid until it sees its done strobe. They also assume that handles are always in range and that valid stays low during reset. The stimulus presents a request only when the requester is idle or its strobe is high. It draws handles only from those the unit returned, and it keeps every request line low until reset is released. A behavioural model in the bench makes its own arbitration choice each cycle and applies the operation to its own copy of the store and bitmap. The responses are then compared cycle by cycle.

// File: rtl/awu_pkg.sv
package awu_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_TAS   = 3'd2,
      OP_XCHG  = 3'd3,
      OP_INC   = 3'd4,
      OP_DEC   = 3'd5,
      OP_ALLOC = 3'd6,
      OP_FREE  = 3'd7
   } awu_op_e;
endpackage

// File: rtl/awu_arbiter.sv
module awu_arbiter #(
   parameter int N_REQ       = 2,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   output logic [N_REQ-1:0] grant
);
   localparam int PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

   generate
      if (N_REQ < 1) begin : g_bad_n
         $error("awu_arbiter: N_REQ must be at least 1");
      end

      if (ROUND_ROBIN) begin : g_rr
         logic [PTR_W-1:0] last_q;
         logic             found;

         always_comb begin
            grant = '0;
            found = 1'b0;
            for (int k = 0; k < N_REQ; k++) begin
               int idx;
               idx = (int'(last_q) + 1 + k) % N_REQ;
               if (!found && req[idx]) begin
                  grant[idx] = 1'b1;
                  found      = 1'b1;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q <= PTR_W'(N_REQ - 1);
            end else if (|grant) begin
               for (int i = 0; i < N_REQ; i++)
                  if (grant[i]) last_q <= PTR_W'(i);
            end
         end

         AST_RR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
            ((&req) && $past(&req) && $past(|grant) && (N_REQ > 1)) |-> (grant != $past(grant))); // R8
      end else begin : g_fixed
         always_comb begin
            grant = '0;
            for (int i = N_REQ - 1; i >= 0; i--)
               if (req[i]) grant = N_REQ'(1) << i;
         end
      end
   endgenerate

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8
   AST_GRANT_WITHIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0); // R8
endmodule

// File: rtl/awu_alu.sv
module awu_alu import awu_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  awu_op_e           op,
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] new_word,
   output logic              word_wr
);
   always_comb begin
      new_word = old_word;
      word_wr  = 1'b1;
      case (op)
         OP_WRITE, OP_XCHG: new_word = operand;
         OP_TAS:            new_word = DATA_W'(1);
         OP_INC:            new_word = old_word + DATA_W'(1);
         OP_DEC:            new_word = old_word - DATA_W'(1);
         default:           word_wr  = 1'b0;
      endcase
   end
endmodule

// File: rtl/awu_freelist.sv
module awu_freelist #(
   parameter int DEPTH = 1024,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_en,
   input  logic             free_en,
   input  logic [IDX_W-1:0] free_handle,
   output logic [IDX_W-1:0] lowest_free,
   output logic             pool_full,
   output logic             handle_used
);
   logic [DEPTH-1:0] used_q;

   always_comb begin
      lowest_free = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (!used_q[i]) lowest_free = IDX_W'(i);
   end

   assign pool_full   = &used_q;
   assign handle_used = used_q[free_handle];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
      end else begin
         if (alloc_en && !pool_full) used_q[lowest_free] <= 1'b1;
         if (free_en)                used_q[free_handle] <= 1'b0;
      end
   end

   AST_ALLOC_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !pool_full) |=> used_q[$past(lowest_free)]); // R9
   AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && pool_full) |=> $stable(used_q)); // R10
   AST_DOUBLE_FREE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (free_en && !handle_used) |=> $stable(used_q)); // R11
endmodule

// File: rtl/atomic_word_unit.sv
module atomic_word_unit import awu_pkg::*; #(
   parameter int N_REQ       = 2,
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 1024,
   parameter bit ROUND_ROBIN = 1'b1,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_REQ-1:0]        req_valid,
   input  logic [N_REQ*OP_W-1:0]   req_op,
   input  logic [N_REQ*IDX_W-1:0]  req_handle,
   input  logic [N_REQ*DATA_W-1:0] req_wdata,
   output logic [N_REQ-1:0]        rsp_done,
   output logic [N_REQ*DATA_W-1:0] rsp_data,
   output logic [N_REQ-1:0]        rsp_err
);
   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("atomic_word_unit: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W <= IDX_W) begin : g_bad_width
         $error("atomic_word_unit: DATA_W must exceed the handle width");
      end
   endgenerate

   logic [N_REQ-1:0]  grant;
   logic [N_REQ-1:0]  done_q;
   logic [N_REQ-1:0]  err_q;
   logic [N_REQ*DATA_W-1:0] data_q;
   logic              any_grant;
   awu_op_e           sel_op;
   logic [IDX_W-1:0]  sel_handle;
   logic [DATA_W-1:0] sel_wdata;
   logic [DATA_W-1:0] old_word, alu_word, res_word;
   logic              alu_wr, res_err;
   logic [IDX_W-1:0]  lowest_free;
   logic              pool_full, handle_used;
   logic              mem_we;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_word;
   logic [DATA_W-1:0] mem [DEPTH];

   awu_arbiter #(.N_REQ(N_REQ), .ROUND_ROBIN(ROUND_ROBIN)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_valid & ~done_q), .grant(grant)
   );

   assign any_grant = |grant;

   always_comb begin
      sel_op     = OP_READ;
      sel_handle = '0;
      sel_wdata  = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (grant[i]) begin
            sel_op     = awu_op_e'(req_op[i*OP_W +: OP_W]);
            sel_handle = req_handle[i*IDX_W +: IDX_W];
            sel_wdata  = req_wdata[i*DATA_W +: DATA_W];
         end
      end
   end

   assign old_word = mem[sel_handle];

   awu_alu #(.DATA_W(DATA_W)) u_alu (
      .op(sel_op), .old_word(old_word), .operand(sel_wdata),
      .new_word(alu_word), .word_wr(alu_wr)
   );

   awu_freelist #(.DEPTH(DEPTH)) u_pool (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(any_grant && sel_op == OP_ALLOC),
      .free_en(any_grant && sel_op == OP_FREE),
      .free_handle(sel_handle),
      .lowest_free(lowest_free), .pool_full(pool_full), .handle_used(handle_used)
   );

   always_comb begin
      res_word = old_word;
      res_err  = 1'b0;
      case (sel_op)
         OP_ALLOC: begin
            res_err  = pool_full;
            res_word = pool_full ? '0 : DATA_W'(lowest_free);
         end
         OP_FREE: res_err = !handle_used;
         default: ;
      endcase
   end

   assign mem_we  = any_grant && (alu_wr || (sel_op == OP_ALLOC && !pool_full));
   assign wr_idx  = (sel_op == OP_ALLOC) ? lowest_free : sel_handle;
   assign wr_word = (sel_op == OP_ALLOC) ? '0 : alu_word;

   always_ff @(posedge clk) begin
      if (mem_we) mem[wr_idx] <= wr_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= '0;
         err_q  <= '0;
         data_q <= '0;
      end else begin
         done_q <= grant;
         for (int i = 0; i < N_REQ; i++) begin
            if (grant[i]) begin
               data_q[i*DATA_W +: DATA_W] <= res_word;
               err_q[i]                   <= res_err;
            end
         end
      end
   end

   assign rsp_done = done_q;
   assign rsp_data = data_q;
   assign rsp_err  = err_q;

   AST_NO_REGRANT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done & grant) == '0); // R8
   AST_TAS_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (any_grant && sel_op == OP_TAS) |=> mem[$past(sel_handle)] == DATA_W'(1)); // R4
   AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (any_grant && sel_op == OP_INC) |=> mem[$past(sel_handle)] == $past(old_word) + DATA_W'(1)); // R6
   AST_DEC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (any_grant && sel_op == OP_DEC) |=> mem[$past(sel_handle)] == $past(old_word) - DATA_W'(1)); // R6
   AST_EXHAUST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (any_grant && sel_op == OP_ALLOC && pool_full) |=> ((rsp_err & rsp_done) == rsp_done)); // R10
   AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (any_grant && sel_op == OP_READ) |=> mem[$past(sel_handle)] == $past(old_word)); // R2
endmodule

// File: tb/test_atomic_word_unit.sv
module test_atomic_word_unit;
   import awu_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 2;
   localparam int DW = 32;
   localparam int DEP = 1024;
   localparam int IW = 10;

   typedef struct {
      awu_op_e     op;
      logic [IW-1:0] h;
      logic [DW-1:0] d;
   } req_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NR-1:0] vld = '0;
   awu_op_e op_a [NR];
   logic [IW-1:0] h_a [NR];
   logic [DW-1:0] d_a [NR];
   logic [NR*OP_W-1:0] req_op;
   logic [NR*IW-1:0]   req_handle;
   logic [NR*DW-1:0]   req_wdata;
   logic [NR-1:0]      rsp_done, rsp_err;
   logic [NR*DW-1:0]   rsp_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int r = 0; r < NR; r++) begin
         req_op[r*OP_W +: OP_W] = op_a[r];
         req_handle[r*IW +: IW] = h_a[r];
         req_wdata[r*DW +: DW]  = d_a[r];
      end
   end

   atomic_word_unit i_atomic_word_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_op(req_op),
      .req_handle(req_handle), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_err(rsp_err)
   );

   int n_chk = 0;
   int n_err = 0;
   req_t q0[$];
   req_t q1[$];
   logic [DW-1:0] m [DEP];
   bit u [DEP];
   int last_g = NR - 1;
   logic [NR-1:0] exp_done = '0;
   logic [DW-1:0] exp_data [NR];
   logic [NR-1:0] exp_err = '0;
   string exp_tag [NR];
   bit rec_on = 1'b0;
   int order[$];
   logic [DW-1:0] last_rd = '0;

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input int r, input awu_op_e op, input int h, input logic [DW-1:0] d);
      req_t e;
      e.op = op; e.h = IW'(h); e.d = d;
      if (r == 0) q0.push_back(e); else q1.push_back(e);
   endtask

   function automatic string tag_of(input awu_op_e op, input bit err);
      case (op)
         OP_READ:  return "R2 read";
         OP_WRITE: return "R3 write";
         OP_TAS:   return "R4 test-and-set";
         OP_XCHG:  return "R5 exchange";
         OP_INC, OP_DEC: return "R6 inc/dec";
         OP_ALLOC: return err ? "R10 exhausted" : "R9 allocate";
         default:  return "R11 free";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         // compare this cycle's outputs with the model
         for (int r = 0; r < NR; r++) begin
            chk(rsp_done[r] == exp_done[r], "R7/R8 done strobe", DW'(rsp_done[r]), DW'(exp_done[r]));
            if (exp_done[r] && rsp_done[r]) begin
               chk(rsp_data[r*DW +: DW] == exp_data[r], exp_tag[r], rsp_data[r*DW +: DW], exp_data[r]);
               chk(rsp_err[r] == exp_err[r], {exp_tag[r], " err"}, DW'(rsp_err[r]), DW'(exp_err[r]));
               if (rec_on) order.push_back(r);
               if (r == 0) last_rd = rsp_data[DW-1:0];
            end
         end
         // present next requests
         for (int r = 0; r < NR; r++) begin
            if (!vld[r] || exp_done[r]) begin
               req_t e;
               bit have;
               have = 1'b0;
               if (r == 0 && q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
               if (r == 1 && q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
               vld[r] = have;
               if (have) begin op_a[r] = e.op; h_a[r] = e.h; d_a[r] = e.d; end
            end
         end
         // model: choose and apply this cycle's operation
         begin
            logic [NR-1:0] elig, nxt_done;
            int g;
            elig = vld & ~exp_done;
            g = -1;
            for (int k = 0; k < NR; k++) begin
               int idx;
               idx = (last_g + 1 + k) % NR;
               if (g < 0 && elig[idx]) g = idx;
            end
            nxt_done = '0;
            if (g >= 0) begin
               logic [DW-1:0] res;
               bit e;
               int h;
               h = int'(h_a[g]);
               e = 1'b0;
               res = m[h];
               case (op_a[g])
                  OP_READ: ;
                  OP_WRITE, OP_XCHG: m[h] = d_a[g];
                  OP_TAS: m[h] = 32'd1;
                  OP_INC: m[h] = m[h] + 32'd1;
                  OP_DEC: m[h] = m[h] - 32'd1;
                  OP_ALLOC: begin
                     int f;
                     f = -1;
                     for (int i = 0; i < DEP; i++) if (f < 0 && !u[i]) f = i;
                     if (f < 0) begin e = 1'b1; res = '0; end
                     else begin u[f] = 1'b1; m[f] = '0; res = DW'(f); end
                  end
                  default: begin
                     if (!u[h]) e = 1'b1; else u[h] = 1'b0;
                  end
               endcase
               nxt_done[g] = 1'b1;
               exp_data[g] = res;
               exp_err[g]  = e;
               exp_tag[g]  = tag_of(op_a[g], e);
               last_g = g;
            end
            exp_done = nxt_done;
         end
      end
   end

   task automatic wait_idle();
      do @(negedge clk); while (q0.size() != 0 || q1.size() != 0 || vld != '0 || exp_done != '0);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NR; i++) begin op_a[i] = OP_READ; h_a[i] = '0; d_a[i] = '0; end
      for (int i = 0; i < DEP; i++) begin u[i] = 1'b0; m[i] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_done == '0, "R1 reset done low", DW'(rsp_done), 32'd0);

      // R9 lowest free from an empty store (R1), then R2-R6 on those words
      push(0, OP_ALLOC, 0, 0); push(0, OP_ALLOC, 0, 0); push(0, OP_ALLOC, 0, 0);
      push(0, OP_WRITE, 0, 32'h1234); push(0, OP_READ, 0, 0);
      push(0, OP_TAS, 1, 0); push(0, OP_TAS, 1, 0);
      push(0, OP_XCHG, 2, 32'hDEAD_BEEF); push(0, OP_WRITE, 2, 32'hFFFF_FFFF);
      push(0, OP_INC, 2, 0); push(0, OP_DEC, 2, 0); push(0, OP_READ, 2, 0);
      wait_idle();

      // R12 and R8: both requesters increment word 0 together
      rec_on = 1'b1;
      for (int i = 0; i < 4; i++) begin push(0, OP_INC, 0, 0); push(1, OP_INC, 0, 0); end
      wait_idle();
      rec_on = 1'b0;
      chk(order.size() == 8, "R8 served count", DW'(order.size()), 32'd8);
      for (int i = 1; i < order.size(); i++)
         chk(order[i] != order[i-1], "R8 alternation", DW'(order[i]), DW'(1 - order[i-1]));
      push(0, OP_READ, 0, 0);
      wait_idle();
      chk(last_rd == 32'h123C, "R12 all increments applied", last_rd, 32'h123C);

      // R11 free, double free, then R9 reuse of the lowest handle
      push(1, OP_FREE, 1, 0); push(1, OP_FREE, 1, 0); push(1, OP_ALLOC, 0, 0);
      wait_idle();

      // R10 exhaustion from both requesters, then recovery
      for (int i = 0; i < 510; i++) push(0, OP_ALLOC, 0, 0);
      for (int i = 0; i < 511; i++) push(1, OP_ALLOC, 0, 0);
      wait_idle();
      push(0, OP_ALLOC, 0, 0); push(1, OP_ALLOC, 0, 0);
      wait_idle();
      push(1, OP_FREE, 5, 0);
      wait_idle();
      push(0, OP_ALLOC, 0, 0);
      wait_idle();

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule